// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast a fan turns. It counts the interval between two rising edges of the fan's tachometer output. The unit of that count is a reference tick, made by dividing a 50 kHz base enable by 2, 4, 8 or 16. A 2-bit selection input chooses the ratio. At each rising tach edge, the count for the interval just ended is moved into an 8-bit result, and a new count starts from zero. A longer result therefore means a slower fan.

The counter can run past its 8-bit range, for example when the rotor has stalled. In that case the block does not wait for an edge that may never arrive. It forces the result to its maximum value at once and raises an overflow flag, which fault logic further along can pick up in the same cycle. The flag stays high until the next rising tach edge starts a fresh interval. The raw tach pin passes through a two-flop synchronizer before its edges are used. The reference-tick divider restarts on every edge, so each interval is counted from a clean phase.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, the result reads 255 (all ones) and the overflow flag is 0.
- R2: The divide selection sets how many base ticks make one reference tick: 2'b11 gives 2, 2'b10 gives 4, 2'b01 gives 8, 2'b00 gives 16 (the reset and default coding). An interval of n base ticks reads back as floor(n / ratio).
- R3: At each rising tach edge, the count for the interval just ended is copied into the result. Between edges the result does not change, except when it is forced on overflow.
- R4: The divider restarts at every rising tach edge, so base ticks left over from the previous interval do not count toward the next one.
- R5: An interval of exactly 255 reference ticks reads 255 and does not raise the overflow flag.
- R6: On the 256th reference tick of an interval, the overflow flag rises and the result becomes 255 in the same clock. No tach edge is needed for this.
- R7: Once raised, the overflow flag stays high until the next rising tach edge. That edge clears the flag and restarts counting from zero.
- R8: The tach pin is synchronized. A rising level first sampled at clock edge k updates the result at clock edge k+2, and not at edge k+1.
- R9: A falling tach edge has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle enable at the 50 kHz base rate |
| div_sel | input | 2 | Reference divide selection (see R2) |
| tach_pin | input | 1 | Raw, asynchronous tachometer input |
| tach_count | output | 8 | Latest measured interval in reference ticks |
| tach_ovf | output | 1 | Interval counter has overflowed since the last rising edge |

## Verification
Some properties are checked on every cycle by assertions in the RTL:
- the edge strobe lasts one cycle;
- the divider returns to zero after an edge;
- the overflow flag holds until an edge, and an edge clears it along with the counter;
- the result moves only on an edge or when it is forced to maximum, and it reads maximum whenever overflow rises.

Other behaviour can only be shown by the bench's scenarios, because it depends on how the stimulus is arranged:
- the values that come out for each divide ratio, including the remainders that are dropped;
- the 255 versus 256 boundary;
- the discarding of leftover base ticks;
- the exact synchronizer latency and the lack of any effect from a falling edge.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    // Reference divide selection; the reset coding selects the slowest rate.
    typedef enum logic [1:0] {
        DIV_BY_16 = 2'b00,
        DIV_BY_8  = 2'b01,
        DIV_BY_4  = 2'b10,
        DIV_BY_2  = 2'b11
    } div_sel_e;

    localparam int unsigned MAX_RATIO  = 16;
    localparam int unsigned PRE_W      = $clog2(MAX_RATIO);
    localparam int unsigned TACH_CNT_W = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    // Synchronized view of the tach pin.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } tach_evt_t;

    function automatic int unsigned div_ratio(div_sel_e sel);
        return MAX_RATIO >> sel;
    endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge
    import fan_tach_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output tach_evt_t evt_o
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin_i};
    end

    always_comb begin
        evt_o.level = sh_q[STAGES-1];
        evt_o.rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
        evt_o.fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
    end

    // R8
    edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o.rise |=> !evt_o.rise);

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler
    import fan_tach_pkg::*;
#(
    parameter int unsigned W = PRE_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     base_tick_i,
    input  div_sel_e sel_i,
    input  logic     restart_i,
    output logic     tick_o
);
    logic [W-1:0] pre_q;
    logic [W-1:0] last_val;
    logic         wrap;

    assign last_val = W'(div_ratio(sel_i) - 1);
    // >= keeps the wrap safe if the selection shrinks mid-interval
    assign wrap     = (pre_q >= last_val);
    assign tick_o   = base_tick_i && !restart_i && wrap;

    always_ff @(posedge clk) begin
        if (rst || restart_i) pre_q <= '0;
        else if (base_tick_i) pre_q <= wrap ? '0 : pre_q + 1'b1;
    end

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (pre_q == '0));

    // R2
    tick_needs_base_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> base_tick_i);

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] res_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            res_q <= CNT_MAX;
            ovf_q <= 1'b0;
        end else if (edge_i) begin
            res_q <= cnt_q;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == CNT_MAX) begin
                ovf_q <= 1'b1;
                res_q <= CNT_MAX;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count_o = res_q;
    assign ovf_o   = ovf_q;

    // R6
    ovf_forces_max_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> (res_q == CNT_MAX));

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !edge_i) |=> ovf_q);

    // R7
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        edge_i |=> ((cnt_q == '0) && !ovf_q));

    // R3
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_i |=> ($stable(res_q) || (res_q == CNT_MAX)));

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int unsigned CNT_W  = TACH_CNT_W,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_tick,
    input  logic [1:0]       div_sel,
    input  logic             tach_pin,
    output logic [CNT_W-1:0] tach_count,
    output logic             tach_ovf
);
    tach_evt_t evt;
    logic      ref_tick;

    tach_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (tach_pin),
        .evt_o (evt)
    );

    tach_prescaler #(.W(PRE_W)) u_pre (
        .clk         (clk),
        .rst         (rst),
        .base_tick_i (base_tick),
        .sel_i       (div_sel_e'(div_sel)),
        .restart_i   (evt.rise),
        .tick_o      (ref_tick)
    );

    tach_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (evt.rise),
        .tick_i  (ref_tick),
        .count_o (tach_count),
        .ovf_o   (tach_ovf)
    );

endmodule

// File: tb/fan_tach_meter_bench.sv
module fan_tach_meter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       tach_pin = 1'b0;
    logic [7:0] tach_count;
    logic       tach_ovf;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fan_tach_meter u_fan_tach_meter (
        .clk        (clk),
        .rst        (rst),
        .base_tick  (base_tick),
        .div_sel    (div_sel),
        .tach_pin   (tach_pin),
        .tach_count (tach_count),
        .tach_ovf   (tach_ovf)
    );

    // Vector table: selection, base ticks in interval, expected result (R2, R3, R5)
    localparam int NV = 10;
    localparam logic [1:0] V_SEL [NV] = '{2'b11, 2'b10, 2'b01, 2'b00, 2'b00,
                                          2'b11, 2'b10, 2'b11, 2'b01, 2'b10};
    localparam int V_N   [NV] = '{10, 10, 20, 40, 15, 1, 400, 510, 16, 7};
    localparam int V_EXP [NV] = '{5, 2, 2, 2, 0, 0, 100, 255, 2, 1};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) base_tick = 1'b1;
            @(negedge clk) base_tick = 1'b0;
        end
    endtask

    // Full tach pulse; the rising edge has taken effect when this returns.
    task automatic tach_pulse();
        @(negedge clk) tach_pin = 1'b1;
        repeat (4) @(negedge clk);
        tach_pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 count", tach_count, 255);
        check("R1 ovf", tach_ovf, 0);

        // Vector walk: R2 ratios and remainders, R3 transfer, R5 boundary
        for (int v = 0; v < NV; v++) begin
            div_sel = V_SEL[v];
            tach_pulse();
            ticks(V_N[v]);
            tach_pulse();
            check($sformatf("R2/R3 vec%0d count", v), tach_count, V_EXP[v]);
            check($sformatf("R5 vec%0d ovf", v), tach_ovf, 0);
        end

        // R8 latency: a rising level sampled at edge k acts at edge k+2
        div_sel = 2'b11;
        tach_pulse();
        ticks(4);
        tach_pulse();
        check("R3 prep", tach_count, 2);
        ticks(6);
        @(negedge clk) tach_pin = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 not yet", tach_count, 2);
        @(negedge clk);
        check("R8 updated", tach_count, 3);

        // R9 falling edge ignored, R3 stable between edges
        tach_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 after fall", tach_count, 3);
        ticks(8);
        check("R3 stable", tach_count, 3);

        // R4 divider restart discards leftover base ticks
        div_sel = 2'b10;
        tach_pulse();
        ticks(3);
        tach_pulse();
        ticks(1);
        tach_pulse();
        check("R4 leftover", tach_count, 0);

        // R5 exactly 255 reference ticks: no overflow before the edge
        div_sel = 2'b11;
        tach_pulse();
        ticks(4);
        tach_pulse();
        ticks(510);
        check("R5 ovf at 255", tach_ovf, 0);
        check("R3 hold before edge", tach_count, 2);
        tach_pulse();
        check("R5 count", tach_count, 255);

        // R6 immediate overflow, R7 hold and clear
        ticks(4);
        tach_pulse();
        check("R3 small", tach_count, 2);
        ticks(511);
        check("R6 before", tach_ovf, 0);
        ticks(1);
        check("R6 ovf", tach_ovf, 1);
        check("R6 count", tach_count, 255);
        ticks(50);
        check("R7 hold", tach_ovf, 1);
        tach_pulse();
        check("R7 clear", tach_ovf, 0);
        check("R7 count", tach_count, 255);
        ticks(6);
        tach_pulse();
        check("R7 restart", tach_count, 3);

        // R1 reset from a running state
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 rerun count", tach_count, 255);
        check("R1 rerun ovf", tach_ovf, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule